// File: doc/BRIEF.md
# Clock-Crossing Host-to-Fabric Bus Bridge with Interrupt Vectoring

This bridge gives a host processor access to registers and memory in an FPGA fabric. The host uses a 16-bit data path and runs on its own clock. It issues accesses in three address spaces: a short 16-bit space, a standard 24-bit space, and a partial window into a 32-bit space. The bridge decodes each request into a byte address in a 25-bit fabric space. It carries the access into the fabric clock domain and brings the result back.

Each access crosses the clock boundary as a toggle request. The toggle is answered by a toggle acknowledge. The fabric sees one strobed cycle per 16-bit halfword. A 32-bit access to the 32-bit window is split into two halfword transfers, high half first. The bridge signals completion only after both halves have finished. A request that no window decodes ends in a bus-error pulse and never reaches the fabric.

The bridge also watches 64 fabric interrupt lines. It presents the lowest-numbered pending line to the host as a vector equal to 192 plus the line number. That vector is held until the host acknowledges it.

Top module: `vme_window_bridge`

## Requirements
- R1: Space code 2'b01 (24-bit space) accepts any 16-bit access. The fabric address is h_addr[23:0] with bit 0 cleared, and h_addr[31:24] is ignored.
- R2: Space code 2'b00 (16-bit space) accepts any 16-bit access. The fabric address is 0x1000000 plus h_addr[15:0] with bit 0 cleared, and h_addr[31:16] is ignored.
- R3: Space code 2'b10 (32-bit window) decodes only when h_addr[31:22] equals 10'h200, that is host addresses 0x80000000 to 0x803FFFFF. The fabric address is 0x1400000 plus h_addr[21:0] with bit 0 cleared.
- R4: With h_size32 high in the 32-bit window, the bridge makes two fabric cycles. The first goes to the decoded address and carries h_wdata[31:16]. The second goes to that address plus 2 and carries h_wdata[15:0]. A read returns {first halfword, second halfword}.
- R5: h_ready pulses for one cycle only after every fabric cycle of the access has been acknowledged. A 16-bit read returns the halfword zero-extended in h_rdata.
- R6: A request with space code 2'b11, with h_size32 high in space 2'b00 or 2'b01, or with a 32-bit-window address outside the window gets h_berr for one cycle in the cycle after the request. It makes no fabric cycle.
- R7: f_cyc stays high with f_addr, f_we and f_wdata stable until f_ack. It drops in the cycle after f_ack, so each halfword makes exactly one fabric cycle.
- R8: When any f_irq line is pending, h_irq rises and h_vec equals 192 plus the lowest pending line number.
- R9: While h_irq is high and h_iack is low, h_vec stays unchanged, even if a lower-numbered line becomes pending.
- R10: An h_iack while h_irq is high drops h_irq in the next cycle. The next lowest pending line is then presented.
- R11: After reset, h_ready, h_berr, h_irq and f_cyc are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst | input | 1 | Host-domain synchronous reset, active high |
| h_req | input | 1 | One-cycle access request |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_space | input | 2 | Address space code |
| h_size32 | input | 1 | 32-bit access |
| h_addr | input | 32 | Host byte address |
| h_wdata | input | 32 | Write data (16-bit writes use bits 15:0) |
| h_rdata | output | 32 | Read data, valid with h_ready |
| h_ready | output | 1 | Access completed |
| h_berr | output | 1 | Access rejected |
| h_irq | output | 1 | Interrupt vector presented |
| h_vec | output | 8 | Interrupt vector number |
| h_iack | input | 1 | Host accepts the presented vector |
| fclk | input | 1 | Fabric clock |
| frst | input | 1 | Fabric-domain synchronous reset, active high |
| f_cyc | output | 1 | Fabric cycle strobe |
| f_we | output | 1 | Fabric write enable |
| f_addr | output | 25 | Fabric byte address |
| f_wdata | output | 16 | Fabric write data |
| f_rdata | input | 16 | Fabric read data, valid with f_ack |
| f_ack | input | 1 | Fabric cycle acknowledge |
| f_irq | input | 64 | Fabric interrupt lines |

## Verification
Directed accesses land on each window's base, on the last halfword of the 32-bit window and just past it, and on odd addresses with garbage in the ignored upper bits. These cases show whether the decode offsets and masks are right. Random mixes of space, size, direction and offset run against a bench memory model. That model catches half-order swaps, dropped halves and stale read data. Interrupt patterns include single lines at 0 and 63, a lower line arriving while a vector is held, and random multi-bit masks. These separate a true lowest-first choice with hold-until-acknowledge from an encoder that re-evaluates every cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HALF_W = 16;
  localparam int HOST_AW = 32;
  localparam int HOST_DW = 2 * HALF_W;

  typedef enum logic [1:0] {
    SP_A16 = 2'b00,
    SP_A24 = 2'b01,
    SP_A32 = 2'b10,
    SP_RSV = 2'b11
  } space_e;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_WAIT = 1'b1
  } hstate_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
#(
  parameter int FAB_AW = 25,
  parameter int A32_WIN_BITS = 22,
  parameter int unsigned A32_TAG = 32'h200
) (
  input  logic [1:0]         space,
  input  logic [HOST_AW-1:0] addr,
  input  logic               size32,
  output logic               hit,
  output logic [FAB_AW-1:0]  fab_addr
);
  localparam logic [FAB_AW-1:0] A16_BASE = FAB_AW'(1) << (FAB_AW - 1);
  localparam logic [FAB_AW-1:0] A32_BASE = A16_BASE + (FAB_AW'(1) << (FAB_AW - 3));

  always_comb begin
    hit = 1'b0;
    fab_addr = '0;
    case (space_e'(space))
      SP_A16: begin
        hit = !size32;
        fab_addr = A16_BASE | FAB_AW'(addr[15:0]);
      end
      SP_A24: begin
        hit = !size32;
        fab_addr = FAB_AW'(addr[23:0]);
      end
      SP_A32: begin
        hit = (addr[HOST_AW-1:A32_WIN_BITS] == A32_TAG[HOST_AW-1-A32_WIN_BITS:0]);
        fab_addr = A32_BASE | FAB_AW'(addr[A32_WIN_BITS-1:0]);
      end
      default: begin
        hit = 1'b0;
        fab_addr = '0;
      end
    endcase
    fab_addr[0] = 1'b0;
  end
endmodule

// File: rtl/hb_host_ctl.sv
module hb_host_ctl
  import hb_pkg::*;
#(
  parameter int FAB_AW = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_req,
  input  logic               h_wr,
  input  logic               h_size32,
  input  logic [HOST_DW-1:0] h_wdata,
  output logic [HOST_DW-1:0] h_rdata,
  output logic               h_ready,
  output logic               h_berr,
  input  logic               dec_hit,
  input  logic [FAB_AW-1:0]  dec_addr,
  output logic               x_req_tgl,
  output logic [FAB_AW-1:0]  x_addr,
  output logic               x_wr,
  output logic [HALF_W-1:0]  x_wdata,
  input  logic               x_ack_tgl,
  input  logic [HALF_W-1:0]  x_rdata
);
  hstate_e           state;
  logic              ack_s1, ack_s2, ack_seen;
  logic              two, first;
  logic [HALF_W-1:0] hi_q, lo_wdata;
  logic              ack_ev;

  assign ack_ev = ack_s2 ^ ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HS_IDLE;
      ack_s1    <= 1'b0;
      ack_s2    <= 1'b0;
      ack_seen  <= 1'b0;
      two       <= 1'b0;
      first     <= 1'b0;
      hi_q      <= '0;
      lo_wdata  <= '0;
      h_rdata   <= '0;
      h_ready   <= 1'b0;
      h_berr    <= 1'b0;
      x_req_tgl <= 1'b0;
      x_addr    <= '0;
      x_wr      <= 1'b0;
      x_wdata   <= '0;
    end else begin
      h_ready <= 1'b0;
      h_berr  <= 1'b0;
      ack_s1  <= x_ack_tgl;
      ack_s2  <= ack_s1;
      case (state)
        HS_IDLE: begin
          if (h_req) begin
            if (!dec_hit) begin
              h_berr <= 1'b1;
            end else begin
              x_addr    <= dec_addr;
              x_wr      <= h_wr;
              x_wdata   <= h_size32 ? h_wdata[HOST_DW-1:HALF_W] : h_wdata[HALF_W-1:0];
              lo_wdata  <= h_wdata[HALF_W-1:0];
              two       <= h_size32;
              first     <= 1'b1;
              x_req_tgl <= ~x_req_tgl;
              state     <= HS_WAIT;
            end
          end
        end
        HS_WAIT: begin
          if (ack_ev) begin
            ack_seen <= ack_s2;
            if (two && first) begin
              hi_q      <= x_rdata;
              first     <= 1'b0;
              x_addr    <= x_addr + FAB_AW'(2);
              x_wdata   <= lo_wdata;
              x_req_tgl <= ~x_req_tgl;
            end else begin
              h_rdata <= two ? {hi_q, x_rdata} : {{HALF_W{1'b0}}, x_rdata};
              h_ready <= 1'b1;
              state   <= HS_IDLE;
            end
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  // R5: completion only follows an acknowledge returned from the fabric domain
  a_r5_ready_after_ack: assert property (@(posedge clk) disable iff (rst)
    h_ready |-> $past(ack_s2 != ack_seen));
  // R6: a bus error answers a request from the previous cycle
  a_r6_berr_from_req: assert property (@(posedge clk) disable iff (rst)
    h_berr |-> $past(h_req));
  a_r6_berr_not_ready: assert property (@(posedge clk) disable iff (rst)
    !(h_berr && h_ready));
endmodule

// File: rtl/hb_fab_port.sv
module hb_fab_port
  import hb_pkg::*;
#(
  parameter int FAB_AW = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x_req_tgl,
  input  logic [FAB_AW-1:0] x_addr,
  input  logic              x_wr,
  input  logic [HALF_W-1:0] x_wdata,
  output logic              x_ack_tgl,
  output logic [HALF_W-1:0] x_rdata,
  output logic              f_cyc,
  output logic              f_we,
  output logic [FAB_AW-1:0] f_addr,
  output logic [HALF_W-1:0] f_wdata,
  input  logic [HALF_W-1:0] f_rdata,
  input  logic              f_ack
);
  logic req_s1, req_s2, req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_s1    <= 1'b0;
      req_s2    <= 1'b0;
      req_seen  <= 1'b0;
      x_ack_tgl <= 1'b0;
      x_rdata   <= '0;
      f_cyc     <= 1'b0;
      f_we      <= 1'b0;
      f_addr    <= '0;
      f_wdata   <= '0;
    end else begin
      req_s1 <= x_req_tgl;
      req_s2 <= req_s1;
      if (f_cyc) begin
        if (f_ack) begin
          f_cyc     <= 1'b0;
          x_rdata   <= f_rdata;
          x_ack_tgl <= ~x_ack_tgl;
        end
      end else if (req_s2 != req_seen) begin
        req_seen <= req_s2;
        f_cyc    <= 1'b1;
        f_we     <= x_wr;
        f_addr   <= x_addr;
        f_wdata  <= x_wdata;
      end
    end
  end

  // R7: the strobe and its payload hold until acknowledged
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (f_cyc && !f_ack) |=> (f_cyc && $stable(f_addr) && $stable(f_we) && $stable(f_wdata)));
  // R7: one acknowledge ends the cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (f_cyc && f_ack) |=> !f_cyc);
endmodule

// File: rtl/hb_irq_enc.sv
module hb_irq_enc #(
  parameter int N_IRQ = 64,
  parameter int VEC_BASE = 192,
  parameter int VEC_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             iack,
  output logic             h_irq,
  output logic [VEC_W-1:0] h_vec
);
  localparam int IDX_W = $clog2(N_IRQ);

  logic [N_IRQ-1:0] stg [SYNC_STAGES];
  logic [N_IRQ-1:0] pend;
  logic [IDX_W-1:0] low_idx;
  logic             any;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= irq_in;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign pend = stg[SYNC_STAGES-1];

  always_comb begin
    low_idx = '0;
    any = 1'b0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        low_idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_irq <= 1'b0;
      h_vec <= '0;
    end else if (h_irq) begin
      if (iack) h_irq <= 1'b0;
    end else if (any) begin
      h_irq <= 1'b1;
      h_vec <= VEC_W'(VEC_BASE) + VEC_W'(low_idx);
    end
  end

  // R9: the presented vector holds until acknowledged
  a_r9_vec_hold: assert property (@(posedge clk) disable iff (rst)
    (h_irq && !iack) |=> (h_irq && $stable(h_vec)));
  // R10: acknowledge withdraws the vector for a cycle
  a_r10_ack_gap: assert property (@(posedge clk) disable iff (rst)
    (h_irq && iack) |=> !h_irq);
  // R8: presented vectors lie in the offset range
  a_r8_vec_range: assert property (@(posedge clk) disable iff (rst)
    h_irq |-> (h_vec >= VEC_W'(VEC_BASE)));
endmodule

// File: rtl/vme_window_bridge.sv
module vme_window_bridge
  import hb_pkg::*;
#(
  parameter int FAB_AW = 25,
  parameter int A32_WIN_BITS = 22,
  parameter int unsigned A32_TAG = 32'h200,
  parameter int N_IRQ = 64,
  parameter int VEC_BASE = 192,
  parameter int VEC_W = 8
) (
  input  logic               hclk,
  input  logic               hrst,
  input  logic               h_req,
  input  logic               h_wr,
  input  logic [1:0]         h_space,
  input  logic               h_size32,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [HOST_DW-1:0] h_wdata,
  output logic [HOST_DW-1:0] h_rdata,
  output logic               h_ready,
  output logic               h_berr,
  output logic               h_irq,
  output logic [VEC_W-1:0]   h_vec,
  input  logic               h_iack,
  input  logic               fclk,
  input  logic               frst,
  output logic               f_cyc,
  output logic               f_we,
  output logic [FAB_AW-1:0]  f_addr,
  output logic [HALF_W-1:0]  f_wdata,
  input  logic [HALF_W-1:0]  f_rdata,
  input  logic               f_ack,
  input  logic [N_IRQ-1:0]   f_irq
);
  logic              dec_hit;
  logic [FAB_AW-1:0] dec_addr;
  logic              x_req_tgl, x_wr, x_ack_tgl;
  logic [FAB_AW-1:0] x_addr;
  logic [HALF_W-1:0] x_wdata, x_rdata;

  hb_decode #(.FAB_AW(FAB_AW), .A32_WIN_BITS(A32_WIN_BITS), .A32_TAG(A32_TAG)) u_dec (
    .space(h_space), .addr(h_addr), .size32(h_size32),
    .hit(dec_hit), .fab_addr(dec_addr)
  );

  hb_host_ctl #(.FAB_AW(FAB_AW)) u_host (
    .clk(hclk), .rst(hrst),
    .h_req(h_req), .h_wr(h_wr), .h_size32(h_size32), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_ready(h_ready), .h_berr(h_berr),
    .dec_hit(dec_hit), .dec_addr(dec_addr),
    .x_req_tgl(x_req_tgl), .x_addr(x_addr), .x_wr(x_wr), .x_wdata(x_wdata),
    .x_ack_tgl(x_ack_tgl), .x_rdata(x_rdata)
  );

  hb_fab_port #(.FAB_AW(FAB_AW)) u_fab (
    .clk(fclk), .rst(frst),
    .x_req_tgl(x_req_tgl), .x_addr(x_addr), .x_wr(x_wr), .x_wdata(x_wdata),
    .x_ack_tgl(x_ack_tgl), .x_rdata(x_rdata),
    .f_cyc(f_cyc), .f_we(f_we), .f_addr(f_addr), .f_wdata(f_wdata),
    .f_rdata(f_rdata), .f_ack(f_ack)
  );

  hb_irq_enc #(.N_IRQ(N_IRQ), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W), .SYNC_STAGES(2)) u_irq (
    .clk(hclk), .rst(hrst), .irq_in(f_irq), .iack(h_iack),
    .h_irq(h_irq), .h_vec(h_vec)
  );
endmodule

// File: tb/sim_vme_window_bridge.sv
`timescale 1ns/1ps
module sim_vme_window_bridge;
  logic        hclk = 0, fclk = 0, hrst = 1, frst = 1;
  logic        h_req = 0, h_wr = 0, h_size32 = 0, h_iack = 0;
  logic [1:0]  h_space = 0;
  logic [31:0] h_addr = 0, h_wdata = 0;
  logic [31:0] h_rdata;
  logic        h_ready, h_berr, h_irq;
  logic [7:0]  h_vec;
  logic        f_cyc, f_we;
  logic [24:0] f_addr;
  logic [15:0] f_wdata;
  logic [15:0] f_rdata = 0;
  logic        f_ack = 0;
  logic [63:0] f_irq = 0;

  int total = 0, bad = 0;

  always #5 hclk = ~hclk;
  always #6.5 fclk = ~fclk;

  vme_window_bridge u0 (.*);

  // fabric model: memory with one-cycle acknowledge, plus a cycle log
  logic [15:0] fmem [int];
  int          fcount = 0;
  logic [24:0] flog_a [256];
  logic [15:0] flog_d [256];
  logic        flog_w [256];

  function automatic logic [15:0] dflt(input logic [24:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  always @(posedge fclk) begin
    if (frst) begin
      f_ack <= 1'b0;
    end else begin
      f_ack <= f_cyc && !f_ack;
      if (f_cyc && !f_ack) begin
        flog_a[fcount % 256] <= f_addr;
        flog_d[fcount % 256] <= f_wdata;
        flog_w[fcount % 256] <= f_we;
        fcount <= fcount + 1;
        if (f_we) fmem[int'(f_addr)] = f_wdata;
        else f_rdata <= fmem.exists(int'(f_addr)) ? fmem[int'(f_addr)] : dflt(f_addr);
      end
    end
  end

  // bench reference model
  logic [15:0] emem [int];

  function automatic logic [15:0] eread(input logic [24:0] a);
    return emem.exists(int'(a)) ? emem[int'(a)] : dflt(a);
  endfunction

  function automatic logic map_addr(input logic [1:0] sp, input logic [31:0] ad,
                                    input logic s32, output logic [24:0] fa);
    fa = '0;
    case (sp)
      2'b00: begin fa = 25'h1000000 + {9'd0, ad[15:1], 1'b0}; return !s32; end
      2'b01: begin fa = {1'b0, ad[23:1], 1'b0}; return !s32; end
      2'b10: begin fa = 25'h1400000 + {3'd0, ad[21:1], 1'b0}; return ad[31:22] == 10'h200; end
      default: return 1'b0;
    endcase
  endfunction

  function automatic int lowest(input logic [63:0] p);
    for (int i = 0; i < 64; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int lb;
  task automatic do_acc(input logic [1:0] sp, input logic [31:0] ad, input logic s32,
                        input logic wr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic rdy, output logic be,
                        output int lat, output int nf);
    lb = fcount;
    @(negedge hclk);
    h_req = 1; h_space = sp; h_addr = ad; h_size32 = s32; h_wr = wr; h_wdata = wd;
    @(negedge hclk);
    h_req = 0;
    rdy = 0; be = 0; rd = 0; lat = -1;
    for (int i = 0; i < 300; i++) begin
      if (h_ready || h_berr) begin
        rdy = h_ready; be = h_berr; rd = h_rdata; lat = i;
        break;
      end
      @(negedge hclk);
    end
    repeat (6) @(negedge hclk);
    nf = fcount - lb;
  endtask

  // full access with expectation against the reference model
  task automatic run_acc(input string req, input logic [1:0] sp, input logic [31:0] ad,
                         input logic s32, input logic wr, input logic [31:0] wd);
    logic [31:0] rd, erd;
    logic        rdy, be, hit;
    logic [24:0] fa;
    int          lat, nf, halves;
    hit = map_addr(sp, ad, s32, fa);
    halves = s32 ? 2 : 1;
    do_acc(sp, ad, s32, wr, wd, rd, rdy, be, lat, nf);
    if (!hit) begin
      check(be && !rdy && lat == 0, {req, " berr next cycle"}, {be, rdy, 32'(lat)}, {1'b1, 1'b0, 32'd0});
      check(nf == 0, {req, " no fabric cycle on miss"}, nf, 0);
      return;
    end
    check(rdy && !be, {req, " ready"}, {rdy, be}, 2'b10);
    check(nf == halves, {req, " fabric cycle count"}, nf, halves);
    if (nf == halves) begin
      check(flog_a[lb % 256] == fa && flog_w[lb % 256] == wr, {req, " first address"},
            flog_a[lb % 256], fa);
      if (s32) check(flog_a[(lb + 1) % 256] == fa + 25'd2, {req, " second address"},
                     flog_a[(lb + 1) % 256], fa + 25'd2);
      if (wr) begin
        check(flog_d[lb % 256] == (s32 ? wd[31:16] : wd[15:0]), {req, " first write data"},
              flog_d[lb % 256], s32 ? wd[31:16] : wd[15:0]);
        if (s32) check(flog_d[(lb + 1) % 256] == wd[15:0], {req, " second write data"},
                       flog_d[(lb + 1) % 256], wd[15:0]);
      end
    end
    if (wr) begin
      if (s32) begin
        emem[int'(fa)] = wd[31:16];
        emem[int'(fa + 25'd2)] = wd[15:0];
      end else begin
        emem[int'(fa)] = wd[15:0];
      end
    end else begin
      erd = s32 ? {eread(fa), eread(fa + 25'd2)} : {16'd0, eread(fa)};
      check(rd == erd, {req, " read data"}, rd, erd);
    end
  endtask

  task automatic ack_irq();
    @(negedge hclk); h_iack = 1;
    @(negedge hclk); h_iack = 0;
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] p;
    int lw;
    void'($urandom(32'd2718));
    repeat (10) @(negedge hclk);
    hrst = 0; frst = 0;
    @(negedge hclk);
    // R11
    check(!h_ready && !h_berr && !h_irq && !f_cyc, "R11 reset outputs",
          {h_ready, h_berr, h_irq, f_cyc}, 4'b0);

    // R1 with junk upper bits, then read back (R5 zero-extension)
    run_acc("R1", 2'b01, 32'hFF001234, 0, 1, 32'h0000BEEF);
    run_acc("R1/R5", 2'b01, 32'h00001235, 0, 0, 0);
    // R2 odd address, junk upper bits
    run_acc("R2", 2'b00, 32'h12345679, 0, 1, 32'h0000C0DE);
    run_acc("R2", 2'b00, 32'hABCD5678, 0, 0, 0);
    run_acc("R2 untouched", 2'b00, 32'h00000010, 0, 0, 0);
    // R3/R4 32-bit split, high half first
    run_acc("R3/R4", 2'b10, 32'h80000100, 1, 1, 32'h11223344);
    run_acc("R4", 2'b10, 32'h80000100, 1, 0, 0);
    run_acc("R5", 2'b10, 32'h80000102, 0, 0, 0);
    run_acc("R3 window top", 2'b10, 32'h803FFFFE, 0, 1, 32'h00007777);
    run_acc("R3 window top", 2'b10, 32'h803FFFFE, 0, 0, 0);
    // R6 misses
    run_acc("R6 past window", 2'b10, 32'h80400000, 0, 1, 32'h1);
    run_acc("R6 below window", 2'b10, 32'h7FFFFFFE, 1, 0, 0);
    run_acc("R6 size32 short space", 2'b00, 32'h00000020, 1, 1, 32'h5);
    run_acc("R6 size32 mid space", 2'b01, 32'h00000020, 1, 0, 0);
    run_acc("R6 reserved space", 2'b11, 32'h00000020, 0, 1, 32'h5);
    // R6: the rejected writes left fabric state unchanged
    run_acc("R6 state kept", 2'b01, 32'h00000020, 0, 0, 0);
    run_acc("R6 state kept", 2'b00, 32'h00000020, 0, 0, 0);

    // random mix (R1..R7)
    for (int n = 0; n < 160; n++) begin
      logic [1:0]  sp;
      logic [31:0] ad;
      logic        s32;
      sp = 2'($urandom % 4);
      ad = $urandom;
      ad[15:0] = 16'(($urandom % 48) * 2 + ($urandom % 2));
      if (sp == 2'b10 && ($urandom % 4) != 0) ad[31:22] = 10'h200;
      s32 = (sp == 2'b10) ? 1'($urandom % 2) : (($urandom % 8) == 0);
      run_acc("R7 random", sp, ad, s32, 1'($urandom % 2), $urandom);
    end

    // interrupts
    f_irq = 0; f_irq[40] = 1; f_irq[5] = 1;
    repeat (6) @(negedge hclk);
    check(h_irq && h_vec == 8'd197, "R8 lowest of 5,40", {h_irq, h_vec}, {1'b1, 8'd197});
    f_irq[2] = 1;
    repeat (6) @(negedge hclk);
    check(h_irq && h_vec == 8'd197, "R9 held despite line 2", {h_irq, h_vec}, {1'b1, 8'd197});
    ack_irq();
    check(!h_irq, "R10 gap after iack", h_irq, 1'b0);
    repeat (2) @(negedge hclk);
    check(h_irq && h_vec == 8'd194, "R10 next vector", {h_irq, h_vec}, {1'b1, 8'd194});
    f_irq = 0; f_irq[63] = 1;
    repeat (6) @(negedge hclk);
    ack_irq();
    repeat (3) @(negedge hclk);
    check(h_irq && h_vec == 8'd255, "R8 line 63", {h_irq, h_vec}, {1'b1, 8'd255});
    f_irq = 0; f_irq[0] = 1;
    repeat (6) @(negedge hclk);
    ack_irq();
    repeat (3) @(negedge hclk);
    check(h_irq && h_vec == 8'd192, "R8 line 0", {h_irq, h_vec}, {1'b1, 8'd192});
    for (int n = 0; n < 24; n++) begin
      p = {$urandom, $urandom};
      if (n % 3 == 0) p = 64'd1 << ($urandom % 64);
      if (p == 0) p = 64'h8000_0000_0000_0000;
      f_irq = p;
      repeat (6) @(negedge hclk);
      ack_irq();
      repeat (3) @(negedge hclk);
      lw = lowest(p);
      check(h_irq && h_vec == 8'(192 + lw), "R8 random mask", {h_irq, h_vec}, {1'b1, 8'(192 + lw)});
    end
    f_irq = 0;
    repeat (6) @(negedge hclk);
    ack_irq();
    repeat (4) @(negedge hclk);
    check(!h_irq, "R10 nothing pending after last iack", h_irq, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule